// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

This block collects hardware interrupt request pulses from a parameterized number of sources and decides which one a small CPU should take next. Each source keeps a pending bit, which a request pulse sets, and a 3-bit priority level, in which zero switches the source off. The CPU side keeps a global enable flag and a 3-bit current priority level. A source is eligible only when the global enable is on, its pending bit is set, and its level is strictly above the CPU level. Among the eligible sources the one with the highest level wins, and a tie goes to the lowest index.

The request output and the winning index follow the stored state combinationally. When the CPU pulses the acknowledge input, the block clears the pending bit of the source it is presenting at that moment. A single register write port updates source words and the CPU word. A combinational read port returns the same words.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A high bit of `hw_req_i` sets that source's pending bit from the next clock edge. The pending bit reads back as bit 0 of the source word.
- R2: A write to source word `k` (address `k`, for `k` below `N_SRC`) loads the level from `reg_wdata_i[3:1]`. If `reg_wdata_i[0]` is 0, the write clears the pending bit. If it is 1, the pending bit keeps its value, so software can never set it.
- R3: A source whose level is 000b is never eligible, whatever its pending bit holds. Levels 001b to 111b rank from lowest to highest.
- R4: `irq_o` is high in the same cycle exactly when some source is eligible. Eligible means the global enable is 1, the pending bit is 1, and the level is strictly greater than the CPU level.
- R5: With the CPU level at 111b, no source is eligible. With the CPU level at n, only levels n+1 and above are eligible.
- R6: `irq_idx_o` gives the eligible source with the highest level. Among equal levels it gives the lowest index.
- R7: `ack_i`, while `irq_o` is high, clears only the pending bit of the source shown on `irq_idx_o`. `ack_i` while `irq_o` is low changes nothing.
- R8: A hardware request in the same cycle as an acknowledge or a software clear of that source leaves the pending bit at 1.
- R9: The global enable, the CPU level, each source's level and each source's pending bit are independent. A write to one word leaves every other word unchanged.
- R10: After reset, every pending bit, every level, the global enable and the CPU level are 0, and `irq_o` is low.
- R11: Address `N_SRC` is the CPU word: bit 0 is the global enable and bits 3:1 are the CPU level. A write to any address above `N_SRC` changes nothing. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | N_SRC | Request pulses, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Write address: source words, then the CPU word |
| reg_wdata_i | input | 4 | Write word: bit 0 is pending or enable, bits 3:1 are the level |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 4 | Read word, same layout as the write word |
| ack_i | input | 1 | CPU acknowledge of the presented source |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_idx_o | output | IDX_W | Index of the presented source |

## Verification
The bench targets equal-level ties, where a design that scanned from the top index would present the wrong source. It checks the boundary case of a level equal to the CPU level, which a non-strict compare would wrongly admit. It drives a request in the same cycle as an acknowledge or a software clear, where a clear-dominant design would lose the interrupt. It also writes 1 to a pending bit, which a naive register would set. Directed steps cover writes to the CPU word and to unused addresses, to show that no other state moves. A long pseudo-random phase then checks the request, the index and the read word against a behavioural model on every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned WORD_W = LVL_W + 1;

  typedef logic [LVL_W-1:0] lvl_t;

  // bit 0: pending / enable, bits 3:1: level
  typedef struct packed {
    lvl_t lvl;
    logic flag;
  } ctrl_word_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import prio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_req_i,
  input  logic       wr_en_i,
  input  ctrl_word_t wr_word_i,
  input  logic       ack_clr_i,
  output logic       pend_o,
  output lvl_t       lvl_o
);
  logic pend_q;
  lvl_t lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      if (wr_en_i) lvl_q <= wr_word_i.lvl;
      // set dominates every clear source
      if (hw_req_i)                                        pend_q <= 1'b1;
      else if (ack_clr_i || (wr_en_i && !wr_word_i.flag)) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;

  assert_req_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_req_i |=> pend_q);
  assert_no_sw_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !hw_req_i) |=> !pend_q);
  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr_i && !hw_req_i) |=> !pend_q);
  assert_req_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_req_i && (ack_clr_i || wr_en_i)) |=> pend_q);
  assert_lvl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(lvl_q));
endmodule

// File: rtl/irq_cpu_state.sv
module irq_cpu_state
  import prio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  ctrl_word_t wr_word_i,
  output logic       ie_o,
  output lvl_t       ipl_o
);
  logic ie_q;
  lvl_t ipl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      ipl_q <= '0;
    end else if (wr_en_i) begin
      ie_q  <= wr_word_i.flag;
      ipl_q <= wr_word_i.lvl;
    end
  end

  assign ie_o  = ie_q;
  assign ipl_o = ipl_q;

  assert_cpu_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ie_q) && $stable(ipl_q)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N_SRC-1:0] elig_i,
  input  lvl_t             lvl_i [N_SRC],
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             win_lvl_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    any_o     = 1'b0;
    idx_o     = '0;
    win_lvl_o = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (elig_i[i] && (lvl_i[i] > win_lvl_o)) begin
        any_o     = 1'b1;
        idx_o     = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned ADDR_W = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  hw_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  ctrl_word_t       wr_word;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] src_we;
  logic [N_SRC-1:0] ack_clr;
  lvl_t             lvl [N_SRC];
  logic             cpu_we;
  logic             ie;
  lvl_t             ipl;
  lvl_t             win_lvl;

  assign wr_word = ctrl_word_t'(reg_wdata_i);
  assign cpu_we  = reg_we_i && (reg_addr_i == ADDR_W'(N_SRC));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_we[g]  = reg_we_i && (reg_addr_i == ADDR_W'(g));
    assign ack_clr[g] = ack_i && irq_o && (irq_idx_o == IDX_W'(g));
    assign elig[g]    = ie && pend[g] && (lvl[g] > ipl);

    irq_src_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hw_req_i  (hw_req_i[g]),
      .wr_en_i   (src_we[g]),
      .wr_word_i (wr_word),
      .ack_clr_i (ack_clr[g]),
      .pend_o    (pend[g]),
      .lvl_o     (lvl[g])
    );

    assert_win_best_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && elig[g]) |->
        ((lvl[g] < win_lvl) || ((lvl[g] == win_lvl) && (IDX_W'(g) >= irq_idx_o))));
  end

  irq_cpu_state u_cpu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cpu_we),
    .wr_word_i (wr_word),
    .ie_o      (ie),
    .ipl_o     (ipl)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .elig_i    (elig),
    .lvl_i     (lvl),
    .any_o     (irq_o),
    .idx_o     (irq_idx_o),
    .win_lvl_o (win_lvl)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < int'(N_SRC); i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = {lvl[i], pend[i]};
    if (rd_addr_i == ADDR_W'(N_SRC)) rd_data_o = {ipl, ie};
  end

  assert_ie_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !irq_o);
  assert_win_elig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> elig[irq_idx_o]);
  assert_ipl_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl == '1) |-> !irq_o);
  assert_win_above_ipl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_lvl > ipl));
  assert_win_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_lvl != '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 8;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  hw_req = '0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [3:0]        reg_wdata = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [3:0]        rd_data;
  logic              ack = 1'b0;
  logic              irq;
  logic [IDX_W-1:0]  irq_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N_SRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ack_i(ack), .irq_o(irq), .irq_idx_o(irq_idx)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R10";

  // behavioural reference state
  int m_pend [N_SRC];
  int m_lvl  [N_SRC];
  int m_ie, m_ipl;
  int e_irq, e_idx;
  int seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N_SRC; i++) begin m_pend[i] = 0; m_lvl[i] = 0; end
    m_ie = 0; m_ipl = 0;
  endtask

  task automatic model_expect();
    int best = 0;
    e_irq = 0; e_idx = 0;
    for (int i = 0; i < N_SRC; i++)
      if (m_ie == 1 && m_pend[i] == 1 && m_lvl[i] > m_ipl && m_lvl[i] > best) begin
        best = m_lvl[i]; e_irq = 1; e_idx = i;
      end
  endtask

  function automatic int model_read(int a);
    if (a < N_SRC) return m_lvl[a] * 2 + m_pend[a];
    if (a == N_SRC) return m_ipl * 2 + m_ie;
    return 0;
  endfunction

  task automatic compare();
    model_expect();
    checks++;
    if (int'(irq) != e_irq) begin
      errors++;
      $display("FAIL %s irq act=%0d exp=%0d t=%0t", tag, irq, e_irq, $time);
    end
    if (e_irq == 1) begin
      checks++;
      if (int'(irq_idx) != e_idx) begin
        errors++;
        $display("FAIL %s idx act=%0d exp=%0d t=%0t", tag, irq_idx, e_idx, $time);
      end
    end
    checks++;
    if (int'(rd_data) != model_read(int'(rd_addr))) begin
      errors++;
      $display("FAIL %s rd[%0d] act=%0h exp=%0h t=%0t", tag, rd_addr, rd_data,
               model_read(int'(rd_addr)), $time);
    end
  endtask

  // inputs already driven after a falling edge
  task automatic cyc();
    int a;
    #1 compare();
    @(posedge clk);
    model_expect();
    a = int'(reg_addr);
    for (int i = 0; i < N_SRC; i++) begin
      if (ack && e_irq == 1 && e_idx == i) m_pend[i] = 0;
      if (reg_we && a == i) begin
        m_lvl[i] = int'(reg_wdata[3:1]);
        if (reg_wdata[0] == 1'b0) m_pend[i] = 0;
      end
      if (hw_req[i]) m_pend[i] = 1;
    end
    if (reg_we && a == N_SRC) begin m_ie = int'(reg_wdata[0]); m_ipl = int'(reg_wdata[3:1]); end
    @(negedge clk);
    hw_req = '0; reg_we = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(int a, int lvl, int flag);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = {3'(lvl), 1'(flag)};
    cyc();
  endtask

  task automatic req(int s);
    hw_req[s] = 1'b1;
    cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R10";  // reset state of every word
    for (int a = 0; a <= N_SRC; a++) begin rd_addr = ADDR_W'(a); cyc(); end

    tag = "R11";  // CPU word at address N_SRC: enable on, level 0
    rd_addr = ADDR_W'(N_SRC);
    wr(N_SRC, 0, 1);
    cyc();

    tag = "R2";   // level write with flag 1 must not set pending
    rd_addr = 2;
    wr(2, 3, 1);
    cyc();

    tag = "R1";
    req(2);
    tag = "R4";
    cyc();

    tag = "R6";   // tie at level 3: lower index wins
    rd_addr = 5;
    wr(5, 3, 1);
    req(5);
    cyc();
    wr(6, 6, 1);
    req(6);
    cyc();

    tag = "R7";   // ack clears only the presented source
    rd_addr = 6;
    ack = 1'b1; cyc();
    rd_addr = 5;
    cyc();

    tag = "R5";   // CPU level boundary
    wr(N_SRC, 7, 1); cyc();
    wr(N_SRC, 3, 1); cyc();
    wr(N_SRC, 2, 1); cyc();
    wr(N_SRC, 0, 1); cyc();

    tag = "R3";   // level 0 pending source never eligible
    rd_addr = 0;
    req(0);
    wr(2, 0, 1);
    wr(5, 0, 1);
    cyc();

    tag = "R7";   // ack with no request pending
    rd_addr = 0;
    ack = 1'b1; cyc();
    cyc();

    tag = "R8";   // request beats ack and software clear
    rd_addr = 4;
    wr(4, 7, 1);
    req(4);
    ack = 1'b1; hw_req[4] = 1'b1; cyc();
    cyc();
    hw_req[4] = 1'b1; reg_we = 1'b1; reg_addr = 4; reg_wdata = 4'b1110; cyc();
    cyc();

    tag = "R2";   // software clear
    wr(4, 7, 0);
    cyc();

    tag = "R9";   // writes touch only their own word
    req(1); req(3);
    wr(1, 5, 1);
    wr(3, 2, 1);
    rd_addr = 1;
    wr(N_SRC, 6, 0); cyc();
    rd_addr = 3; cyc();
    wr(1, 5, 0);
    rd_addr = ADDR_W'(N_SRC); cyc();
    rd_addr = 3; cyc();
    wr(N_SRC, 1, 1); cyc();

    tag = "R11";  // unused addresses ignore writes, read 0
    for (int a = N_SRC + 1; a < (1 << ADDR_W); a++) begin
      rd_addr = ADDR_W'(a);
      wr(a, 7, 1);
    end
    for (int a = 0; a <= N_SRC; a++) begin rd_addr = ADDR_W'(a); cyc(); end

    tag = "R6";   // pseudo-random mix compared every cycle
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N_SRC; i++) hw_req[i] = (rnd() % 9) == 0;
      if (rnd() % 4 == 0) begin
        reg_we = 1'b1;
        reg_addr = ADDR_W'(rnd() % (N_SRC + 2));
        reg_wdata = 4'(rnd());
        if (reg_addr == ADDR_W'(N_SRC) && rnd() % 3 != 0) reg_wdata[0] = 1'b1;
      end
      ack = (rnd() % 3) == 0;
      rd_addr = ADDR_W'(rnd() % (1 << ADDR_W));
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule